// File: doc/BRIEF.md
# Privileged Instruction Permission Checker

This block rules on whether three kinds of privileged instruction may run: wait-for-interrupt, the address-translation fence, and the two hypervisor fences (one for guest-virtual and one for guest-physical translations). Each request carries an instruction class and the hart context: current privilege, the virtualization flag, the timeout-wait and trap-translation bits of the machine status register, and the guest trap-translation bit of the hypervisor status register. The block returns one of three verdicts: allow, illegal-instruction, or virtual-instruction fault. An allowed wait also raises a halt strobe. An allowed fence also raises a flush strobe.

Requests arrive on a valid-qualified input with no ready signal, so the block never applies back-pressure. It accepts a new request on every cycle. Exactly one clock edge after a request is presented, the verdict and its strobe appear, qualified by `rsp_valid`. The downstream trap logic must consume the response in that cycle, because the block holds nothing in a queue. A parameter removes hypervisor support. In that configuration the virtualization flag is ignored and no virtual-instruction fault can ever be produced.

Top module: `priv_perm_chk`

## Requirements
- R1: While reset is active and in the first cycle after it is released, `rsp_valid`, `rsp_result`, `rsp_halt` and `rsp_flush` are all 0.
- R2: `rsp_valid` equals `req_valid` delayed by one clock. A response cycle carries the verdict for the request sampled at the previous edge. A cycle with no response shows result 0 and both strobes low. Class encoding: 0 wait, 1 translation fence, 2 hypervisor guest-virtual fence, 3 hypervisor guest-physical fence. Result encoding: 0 allow, 1 illegal-instruction, 2 virtual-instruction fault.
- R3: With hypervisor support, a wait gets a virtual-instruction fault when it runs in supervisor mode with the timeout-wait bit set, or while virtualized. Otherwise it is allowed. Privilege encoding: 0 user, 1 supervisor, 3 machine; the value 2 is treated as user.
- R4: A translation fence gets illegal-instruction when the privilege is below supervisor, or when it runs in supervisor mode with the trap-translation bit set.
- R5: A translation fence that passes R4 gets a virtual-instruction fault when it runs virtualized with the guest trap-translation bit set. Otherwise it is allowed.
- R6: Either hypervisor fence gets a virtual-instruction fault when it runs in supervisor mode while virtualized.
- R7: A hypervisor fence is allowed in machine mode, or in supervisor mode when not virtualized. Any other case not covered by R6 gets illegal-instruction.
- R8: The guest-physical fence gets illegal-instruction when it runs in non-virtualized supervisor mode with the trap-translation bit set. Apart from that it follows R6 and R7.
- R9: `rsp_halt` is high only with an allow verdict for a wait. `rsp_flush` is high only with an allow verdict for a fence class (1, 2 or 3). The two strobes are never high together.
- R10: With hypervisor support disabled, the virtualization flag and the guest trap-translation bit have no effect, and result 2 never appears. A wait in supervisor mode with the timeout-wait bit set gets illegal-instruction instead of a virtual-instruction fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_class | input | 2 | Instruction class (R2 encoding) |
| req_priv | input | 2 | Current privilege (R3 encoding) |
| req_virt | input | 1 | Hart is running virtualized |
| st_tw | input | 1 | Machine status timeout-wait bit |
| st_tvm | input | 1 | Machine status trap-translation bit |
| hst_vtvm | input | 1 | Hypervisor status guest trap-translation bit |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_result | output | 2 | Verdict (R2 encoding) |
| rsp_halt | output | 1 | Halt strobe for an allowed wait |
| rsp_flush | output | 1 | Flush strobe for an allowed fence |

## Verification
The bench aims at the cases where rules have to be ordered. One is a translation fence in supervisor mode with both trap bits set while virtualized: it must be illegal, not a virtual fault, and a design that checks the guest bit first reports the wrong fault. Another is a guest-physical fence in non-virtualized supervisor mode with the trap-translation bit set: it must be illegal, while the guest-virtual fence in the same context is allowed. A design that shares one fence path for both would flush where it should trap. The bench also runs a build without hypervisor support, where a design that leaks the virtualization flag would emit a virtual fault or suppress a halt. It also sends the reserved privilege value 2, which a magnitude compare would wrongly rank above supervisor.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  localparam int CLS_W  = 2;
  localparam int PRIV_W = 2;
  localparam int RES_W  = 2;

  localparam logic [CLS_W-1:0] CLS_WAIT   = 2'd0;
  localparam logic [CLS_W-1:0] CLS_XFENCE = 2'd1;
  localparam logic [CLS_W-1:0] CLS_HFV    = 2'd2;
  localparam logic [CLS_W-1:0] CLS_HFG    = 2'd3;

  localparam logic [PRIV_W-1:0] PL_USER  = 2'd0;
  localparam logic [PRIV_W-1:0] PL_SUPER = 2'd1;
  localparam logic [PRIV_W-1:0] PL_MACH  = 2'd3;

  localparam logic [RES_W-1:0] RES_ALLOW = 2'd0;
  localparam logic [RES_W-1:0] RES_ILL   = 2'd1;
  localparam logic [RES_W-1:0] RES_VF    = 2'd2;

  typedef struct packed {
    logic is_s;
    logic is_m;
    logic virt;
  } mode_t;

  typedef struct packed {
    logic [RES_W-1:0] res;
    logic             go;
  } rule_t;
endpackage

// File: rtl/ppc_mode_decode.sv
module ppc_mode_decode
  import ppc_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic [PRIV_W-1:0] priv,
  input  logic              virt_in,
  input  logic              vtvm_in,
  output mode_t             mode,
  output logic              vtvm_eff
);
  always_comb begin
    mode.is_s = (priv == PL_SUPER);
    mode.is_m = (priv == PL_MACH);
  end

  generate
    if (HYP_EN) begin : g_hyp
      assign mode.virt = virt_in;
      assign vtvm_eff  = vtvm_in;
    end else begin : g_nohyp
      logic unused_hyp;
      assign unused_hyp = virt_in ^ vtvm_in;
      assign mode.virt  = 1'b0;
      assign vtvm_eff   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/ppc_wait_rule.sv
module ppc_wait_rule
  import ppc_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  mode_t mode,
  input  logic  tw,
  output rule_t verdict
);
  logic trap;
  assign trap = (mode.is_s && tw) || mode.virt;

  always_comb begin
    verdict.go  = !trap;
    verdict.res = RES_ALLOW;
    if (trap) verdict.res = HYP_EN ? RES_VF : RES_ILL;
  end
endmodule

// File: rtl/ppc_xfence_rule.sv
module ppc_xfence_rule
  import ppc_pkg::*;
(
  input  mode_t mode,
  input  logic  tvm,
  input  logic  vtvm,
  output rule_t verdict
);
  logic low_priv;
  assign low_priv = !(mode.is_s || mode.is_m);

  always_comb begin
    verdict.go  = 1'b0;
    verdict.res = RES_ALLOW;
    if (low_priv || (mode.is_s && tvm)) begin
      verdict.res = RES_ILL;
    end else if (mode.virt && vtvm) begin
      verdict.res = RES_VF;
    end else begin
      verdict.go = 1'b1;
    end
  end
endmodule

// File: rtl/ppc_hfence_rule.sv
module ppc_hfence_rule
  import ppc_pkg::*;
#(
  parameter bit GPA_VARIANT = 1'b0
) (
  input  mode_t mode,
  input  logic  tvm,
  output rule_t verdict
);
  logic gpa_trap;

  generate
    if (GPA_VARIANT) begin : g_gpa
      assign gpa_trap = mode.is_s && !mode.virt && tvm;
    end else begin : g_gva
      logic unused_tvm;
      assign unused_tvm = tvm;
      assign gpa_trap   = 1'b0;
    end
  endgenerate

  always_comb begin
    verdict.go  = 1'b0;
    verdict.res = RES_ILL;
    if (gpa_trap) begin
      verdict.res = RES_ILL;
    end else if (mode.is_s && mode.virt) begin
      verdict.res = RES_VF;
    end else if (mode.is_m || (mode.is_s && !mode.virt)) begin
      verdict.res = RES_ALLOW;
      verdict.go  = 1'b1;
    end
  end
endmodule

// File: rtl/priv_perm_chk.sv
module priv_perm_chk
  import ppc_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CLS_W-1:0] req_class,
  input  logic [PRIV_W-1:0] req_priv,
  input  logic             req_virt,
  input  logic             st_tw,
  input  logic             st_tvm,
  input  logic             hst_vtvm,
  output logic             rsp_valid,
  output logic [RES_W-1:0] rsp_result,
  output logic             rsp_halt,
  output logic             rsp_flush
);
  mode_t mode;
  logic  vtvm_eff;
  rule_t v_wait, v_xf, v_hfv, v_hfg, v_sel;

  ppc_mode_decode #(.HYP_EN(HYP_EN)) u_mode (
    .priv(req_priv), .virt_in(req_virt), .vtvm_in(hst_vtvm),
    .mode(mode), .vtvm_eff(vtvm_eff)
  );

  ppc_wait_rule #(.HYP_EN(HYP_EN)) u_wait (
    .mode(mode), .tw(st_tw), .verdict(v_wait)
  );

  ppc_xfence_rule u_xf (
    .mode(mode), .tvm(st_tvm), .vtvm(vtvm_eff), .verdict(v_xf)
  );

  ppc_hfence_rule #(.GPA_VARIANT(1'b0)) u_hfv (
    .mode(mode), .tvm(st_tvm), .verdict(v_hfv)
  );

  ppc_hfence_rule #(.GPA_VARIANT(1'b1)) u_hfg (
    .mode(mode), .tvm(st_tvm), .verdict(v_hfg)
  );

  always_comb begin
    unique case (req_class)
      CLS_WAIT:   v_sel = v_wait;
      CLS_XFENCE: v_sel = v_xf;
      CLS_HFV:    v_sel = v_hfv;
      default:    v_sel = v_hfg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_result <= RES_ALLOW;
      rsp_halt   <= 1'b0;
      rsp_flush  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_result <= req_valid ? v_sel.res : RES_ALLOW;
      rsp_halt   <= req_valid && v_sel.go && (req_class == CLS_WAIT);
      rsp_flush  <= req_valid && v_sel.go && (req_class != CLS_WAIT);
    end
  end
endmodule

// File: rtl/ppc_chk.sv
module ppc_chk
  import ppc_pkg::*;
#(
  parameter bit HYP_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [CLS_W-1:0] req_class,
  input logic [PRIV_W-1:0] req_priv,
  input logic             req_virt,
  input logic             rsp_valid,
  input logic [RES_W-1:0] rsp_result,
  input logic             rsp_halt,
  input logic             rsp_flush
);
  logic seen_edge;
  always_ff @(posedge clk) begin
    if (!rst_n) seen_edge <= 1'b0;
    else        seen_edge <= 1'b1;
  end

  // R2
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_edge |-> (rsp_valid == $past(req_valid)));

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> (rsp_result == RES_ALLOW && !rsp_halt && !rsp_flush));

  // R9
  strobe_allow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_halt || rsp_flush) |-> (rsp_valid && rsp_result == RES_ALLOW));

  // R9
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rsp_halt, rsp_flush}) <= 1);

  // R2
  result_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_result != 2'd3);

  // R10
  no_vfault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!HYP_EN) |-> (rsp_result != RES_VF));

  // R7
  mach_hfence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && $past(req_valid && req_priv == PL_MACH && req_class == CLS_HFV))
      |-> rsp_flush);

  // R4
  user_xfence_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && $past(req_valid && req_priv == PL_USER && req_class == CLS_XFENCE))
      |-> (rsp_result == RES_ILL));

  // R3
  mach_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_edge && $past(req_valid && req_priv == PL_MACH && !req_virt
                        && req_class == CLS_WAIT)) |-> rsp_halt);
endmodule

bind priv_perm_chk ppc_chk #(.HYP_EN(HYP_EN)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
  .req_priv(req_priv), .req_virt(req_virt), .rsp_valid(rsp_valid),
  .rsp_result(rsp_result), .rsp_halt(rsp_halt), .rsp_flush(rsp_flush)
);

// File: tb/priv_perm_chk_tb.sv
module priv_perm_chk_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [1:0] req_class, req_priv;
  logic req_virt, st_tw, st_tvm, hst_vtvm;
  logic rsp_valid, rsp_halt, rsp_flush;
  logic [1:0] rsp_result;
  logic nh_valid, nh_halt, nh_flush;
  logic [1:0] nh_result;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  priv_perm_chk #(.HYP_EN(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_priv(req_priv), .req_virt(req_virt), .st_tw(st_tw), .st_tvm(st_tvm),
    .hst_vtvm(hst_vtvm), .rsp_valid(rsp_valid), .rsp_result(rsp_result),
    .rsp_halt(rsp_halt), .rsp_flush(rsp_flush)
  );

  priv_perm_chk #(.HYP_EN(1'b0)) dut_nh_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_priv(req_priv), .req_virt(req_virt), .st_tw(st_tw), .st_tvm(st_tvm),
    .hst_vtvm(hst_vtvm), .rsp_valid(nh_valid), .rsp_result(nh_result),
    .rsp_halt(nh_halt), .rsp_flush(nh_flush)
  );

  // Expected verdict from the requirement text: {result, halt, flush}
  function automatic logic [3:0] expect_v(input logic [1:0] cls, input logic [1:0] pr,
                                          input logic vi, input logic tw, input logic tvm,
                                          input logic vtvm, input bit hyp);
    logic s, m, v;
    logic [1:0] r;
    s = (pr == 2'd1);
    m = (pr == 2'd3);
    v = hyp ? vi : 1'b0;
    case (cls)
      2'd0: begin
        if ((s && tw) || v) r = hyp ? 2'd2 : 2'd1;
        else r = 2'd0;
        return {r, (r == 2'd0), 1'b0};
      end
      2'd1: begin
        if (!(s || m) || (s && tvm)) r = 2'd1;
        else if (v && vtvm && hyp) r = 2'd2;
        else r = 2'd0;
      end
      default: begin
        if (cls == 2'd3 && s && !v && tvm) r = 2'd1;
        else if (s && v) r = 2'd2;
        else if (m || s) r = 2'd0;
        else r = 2'd1;
      end
    endcase
    return {r, 1'b0, (r == 2'd0)};
  endfunction

  task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got res=%0d halt=%0b flush=%0b, expected res=%0d halt=%0b flush=%0b",
               tag, act[3:2], act[1], act[0], exp[3:2], exp[1], exp[0]);
    end
  endtask

  function automatic string tag_for(input logic [1:0] cls, input logic [1:0] pr,
                                    input logic vi, input logic tvm);
    case (cls)
      2'd0: return "R3";
      2'd1: return (!(pr == 2'd1 || pr == 2'd3) || (pr == 2'd1 && tvm)) ? "R4" : "R5";
      2'd2: return (pr == 2'd1 && vi) ? "R6" : "R7";
      default: return "R8";
    endcase
  endfunction

  // Drive one request at a falling edge, check both DUTs at the next falling edge
  task automatic one_req(input logic [1:0] cls, input logic [1:0] pr, input logic vi,
                         input logic tw, input logic tvm, input logic vtvm);
    logic [3:0] e1, e0;
    req_valid = 1'b1; req_class = cls; req_priv = pr; req_virt = vi;
    st_tw = tw; st_tvm = tvm; hst_vtvm = vtvm;
    e1 = expect_v(cls, pr, vi, tw, tvm, vtvm, 1'b1);
    e0 = expect_v(cls, pr, vi, tw, tvm, vtvm, 1'b0);
    @(negedge clk);
    check(tag_for(cls, pr, vi, tvm), {rsp_result, rsp_halt, rsp_flush}, e1);
    check("R10", {nh_result, nh_halt, nh_flush}, e0);
    check("R2", {3'b000, rsp_valid}, 4'b0001);
    check("R9", {2'b00, rsp_halt & rsp_flush, 1'b0}, 4'b0000);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    rst_n = 1'b0; req_valid = 1'b0; req_class = '0; req_priv = '0;
    req_virt = 1'b0; st_tw = 1'b0; st_tvm = 1'b0; hst_vtvm = 1'b0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet during reset even with a request present
    req_valid = 1'b1; req_class = 2'd1; req_priv = 2'd3;
    @(negedge clk);
    check("R1", {rsp_result, rsp_halt, rsp_flush}, 4'b0000);
    check("R1", {3'b000, rsp_valid}, 4'b0000);
    req_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {rsp_result, rsp_halt, rsp_flush, rsp_valid} == 5'd0 ? 4'd0 : 4'd1, 4'd0);

    // Directed corner cases
    one_req(2'd1, 2'd1, 1'b1, 1'b0, 1'b1, 1'b1); // R4 before R5
    one_req(2'd1, 2'd1, 1'b1, 1'b0, 1'b0, 1'b1); // R5 vfault
    one_req(2'd1, 2'd2, 1'b0, 1'b0, 1'b0, 1'b0); // R4 reserved privilege
    one_req(2'd3, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0); // R8 gpa trap
    one_req(2'd2, 2'd1, 1'b0, 1'b0, 1'b1, 1'b0); // R7 gva allowed
    one_req(2'd2, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); // R7 user virt illegal
    one_req(2'd3, 2'd1, 1'b1, 1'b0, 1'b1, 1'b0); // R6 vfault
    one_req(2'd0, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0); // R3 / R10 S+TW
    one_req(2'd0, 2'd0, 1'b1, 1'b0, 1'b0, 1'b0); // R3 virtualized user wait
    one_req(2'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0); // R3 user wait allowed

    // R2: idle cycle after a request gives a quiet response
    req_valid = 1'b0;
    @(negedge clk);
    check("R2", {rsp_result, rsp_halt, rsp_flush}, 4'b0000);
    check("R2", {3'b000, rsp_valid}, 4'b0000);

    // Random mix with occasional idle cycles
    for (int i = 0; i < 600; i++) begin
      logic [31:0] rv;
      rv = $urandom;
      if (rv[31:29] == 3'd0) begin
        req_valid = 1'b0;
        req_class = rv[1:0];
        @(negedge clk);
        check("R2", {rsp_result, rsp_halt, rsp_flush, rsp_valid} == 5'd0 ? 4'd0 : 4'd1, 4'd0);
      end else begin
        one_req(rv[1:0], rv[3:2], rv[4], rv[5], rv[6], rv[7]);
      end
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule